// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block copies a block of words between one I/O device and memory, so that the processor does not handle each word. The processor sets it up while it still owns the bus. It writes a base address, a word count and a control word that picks the direction and the bus-use policy and also launches the run. The engine then asks the processor for the bus with `bus_req` and waits for `bus_grant`. While it holds the bus it drives the memory address and strobes, and it trades words with the device over two valid/ready streams.

Two bus policies are offered. Block mode keeps the bus for the whole block. Word-stealing mode gives the bus back after every word. After it lowers its request the engine always waits for the grant to fall before asking again. When the last word has moved, a done bit and an interrupt line rise, and any write to the control register clears them.

Device streams follow valid/ready rules. A word moves on a clock edge where valid and ready are both high. A source that raises valid keeps it high, with its data unchanged, until the word is taken. Ready may rise or fall in any cycle. Memory is a simple synchronous port: a write takes place at the edge where `mem_wr` is high, and read data appear on `mem_rdata` in the cycle after `mem_rd`.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, `bus_req`, `irq`, both memory strobes, `dev_out_valid` and `dev_in_ready` are low, and every register reads as zero.
- R2: When `cpu_sel` is high and `bus_grant` is low, `cpu_rdata` shows the register chosen by `cpu_rsel`: 0 = base address, 1 = word count, 2 = control, 3 = reads zero. Control bits: bit 0 is start (write 1 to launch; it always reads 0), bit 1 is direction (0 = memory to device, 1 = device to memory), bit 2 is policy (0 = block, 1 = word-stealing), and bit 3 is done (read only).
- R3: A register write is ignored while `bus_grant` is high or while a run is in progress, including the gaps between stolen words.
- R4: In the cycle after a start write with a nonzero count, `bus_req` is high. No memory strobe or device handshake takes place until `bus_grant` is high.
- R5: In memory-to-device runs, each word is read with `mem_rd` at the current address and then offered on `dev_out_data`. While `dev_out_valid` is high and `dev_out_ready` is low, the word stays unchanged.
- R6: In device-to-memory runs, `dev_in_ready` is high while the engine waits for a word. Each accepted word is written with a single-cycle `mem_wr` at the current address.
- R7: The address register goes up by one and the count register goes down by one for every word moved. Between stolen words, the count reads as the number of words still to move.
- R8: In block mode, a run uses exactly one bus tenure.
- R9: In word-stealing mode, `bus_req` falls after every word, so a run of N words uses N tenures. The request does not rise again while `bus_grant` is still high.
- R10: When the count reaches zero, `bus_req` falls and both done and `irq` go high. A write to the control register clears both.
- R11: A start with a count of zero sets done and `irq` at once, and `bus_req` never rises.
- R12: `mem_rd` and `mem_wr` are only high while `bus_grant` is high, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Processor selects the engine |
| cpu_wr | input | 1 | Write strobe for the selected register |
| cpu_rsel | input | 2 | Register select |
| cpu_wdata | input | DW | Register write data |
| cpu_rdata | output | DW | Register read data (zero when not selected or bus granted) |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| mem_addr | output | AW | Memory address, zero when no strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after `mem_rd` |
| dev_out_valid | output | 1 | Word offered to the device |
| dev_out_ready | input | 1 | Device takes the offered word |
| dev_out_data | output | DW | Word to the device |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_ready | output | 1 | Engine can take a device word |
| dev_in_data | input | DW | Word from the device |
| irq | output | 1 | Run finished |

## Verification
A wrong count register shows up at the ports within one word time. The engine either lowers `bus_req` early, leaving words missing at the device or in memory, or keeps requesting after the last word, so the tenure total and the final count readback both come out wrong. A wrong address register shows on the very next strobe as a word landing at, or coming from, the wrong memory location. A wrong state in the sequencer shows as a stolen-word gap in which the request does not fall, or as a strobe outside a grant. The tenure count per run and the count readback taken during a gap catch these within the same run.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int RSW = 2;

  localparam logic [RSW-1:0] RS_BASE = 2'd0;
  localparam logic [RSW-1:0] RS_LEFT = 2'd1;
  localparam logic [RSW-1:0] RS_CTRL = 2'd2;

  localparam int CB_START = 0;
  localparam int CB_DIR   = 1;
  localparam int CB_STEAL = 2;
  localparam int CB_DONE  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASK,
    ST_RD,
    ST_CAP,
    ST_SEND,
    ST_GET,
    ST_WR,
    ST_LET
  } eng_state_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_sel,
  input  logic           cpu_wr,
  input  logic [RSW-1:0] cpu_rsel,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  input  logic           bus_grant,
  input  logic           busy,
  input  logic           step,
  output logic           go,
  output logic [AW-1:0]  addr_q,
  output logic           dir_q,
  output logic           steal_q,
  output logic           done_q,
  output logic           cnt_last,
  output logic           cnt_zero
);
  logic [CW-1:0] cnt_q;
  logic          wr_ok;
  logic          start_cmd;

  assign wr_ok     = cpu_sel && cpu_wr && !bus_grant && !busy;
  assign start_cmd = wr_ok && (cpu_rsel == RS_CTRL) && cpu_wdata[CB_START];
  assign cnt_zero  = (cnt_q == '0);
  assign cnt_last  = (cnt_q == CW'(1));
  assign go        = start_cmd && !cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      steal_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (wr_ok) begin
      case (cpu_rsel)
        RS_BASE: addr_q <= cpu_wdata[AW-1:0];
        RS_LEFT: cnt_q  <= cpu_wdata[CW-1:0];
        RS_CTRL: begin
          dir_q   <= cpu_wdata[CB_DIR];
          steal_q <= cpu_wdata[CB_STEAL];
          done_q  <= start_cmd && cnt_zero;
        end
        default: ;
      endcase
    end else if (step) begin
      addr_q <= addr_q + AW'(1);
      cnt_q  <= cnt_q - CW'(1);
      if (cnt_last) done_q <= 1'b1;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_sel && !bus_grant) begin
      case (cpu_rsel)
        RS_BASE: cpu_rdata = DW'(addr_q);
        RS_LEFT: cpu_rdata = DW'(cnt_q);
        RS_CTRL: begin
          cpu_rdata[CB_DIR]   = dir_q;
          cpu_rdata[CB_STEAL] = steal_q;
          cpu_rdata[CB_DONE]  = done_q;
        end
        default: cpu_rdata = '0;
      endcase
    end
  end

  assert_locked_regs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_wr && (bus_grant || busy) && !step)
      |=> ($stable(addr_q) && $stable(cnt_q) && $stable(dir_q) && $stable(steal_q)));

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !cnt_zero);

  assert_empty_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && cpu_rsel == RS_CTRL && cpu_wdata[CB_START] && cnt_zero) |=> done_q);

  assert_done_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> cnt_zero);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          dir,
  input  logic          steal,
  input  logic          cnt_last,
  input  logic          cnt_zero,
  input  logic [AW-1:0] addr,
  input  logic          bus_grant,
  output logic          bus_req,
  output logic          busy,
  output logic          step,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          dev_out_valid,
  input  logic          dev_out_ready,
  output logic [DW-1:0] dev_out_data,
  input  logic          dev_in_valid,
  output logic          dev_in_ready,
  input  logic [DW-1:0] dev_in_data
);
  eng_state_t    st, st_nx;
  logic [DW-1:0] word_q;
  logic          leave;

  assign leave = cnt_last || steal;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (go) st_nx = ST_ASK;
      ST_ASK:  if (bus_grant) st_nx = dir ? ST_GET : ST_RD;
      ST_RD:   st_nx = ST_CAP;
      ST_CAP:  st_nx = ST_SEND;
      ST_SEND: if (dev_out_ready) st_nx = leave ? ST_LET : ST_RD;
      ST_GET:  if (dev_in_valid) st_nx = ST_WR;
      ST_WR:   st_nx = leave ? ST_LET : ST_GET;
      ST_LET:  if (!bus_grant) st_nx = cnt_zero ? ST_IDLE : ST_ASK;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            word_q <= '0;
    else if (st == ST_CAP)                 word_q <= mem_rdata;
    else if (st == ST_GET && dev_in_valid) word_q <= dev_in_data;
  end

  assign bus_req       = (st != ST_IDLE) && (st != ST_LET);
  assign busy          = (st != ST_IDLE);
  assign mem_rd        = (st == ST_RD);
  assign mem_wr        = (st == ST_WR);
  assign mem_addr      = (mem_rd || mem_wr) ? addr : '0;
  assign mem_wdata     = mem_wr ? word_q : '0;
  assign dev_out_valid = (st == ST_SEND);
  assign dev_out_data  = word_q;
  assign dev_in_ready  = (st == ST_GET);
  assign step          = (dev_out_valid && dev_out_ready) || mem_wr;

  assert_strobe_in_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> bus_grant);

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_steal_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && steal) |=> !bus_req);

  assert_regrant_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && bus_grant) |=> !bus_req);

  assert_block_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !steal && !cnt_last) |=> bus_req);

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid && !dev_out_ready) |=> (dev_out_valid && $stable(dev_out_data)));

  assert_ask_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (bus_req && !mem_rd && !mem_wr && !dev_in_ready && !dev_out_valid));
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_sel,
  input  logic           cpu_wr,
  input  logic [RSW-1:0] cpu_rsel,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  output logic           bus_req,
  input  logic           bus_grant,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           dev_out_valid,
  input  logic           dev_out_ready,
  output logic [DW-1:0]  dev_out_data,
  input  logic           dev_in_valid,
  output logic           dev_in_ready,
  input  logic [DW-1:0]  dev_in_data,
  output logic           irq
);
  logic          busy, step, go;
  logic          dir_q, steal_q, done_q;
  logic          cnt_last, cnt_zero;
  logic [AW-1:0] addr_q;

  dma_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_rsel  (cpu_rsel),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .bus_grant (bus_grant),
    .busy      (busy),
    .step      (step),
    .go        (go),
    .addr_q    (addr_q),
    .dir_q     (dir_q),
    .steal_q   (steal_q),
    .done_q    (done_q),
    .cnt_last  (cnt_last),
    .cnt_zero  (cnt_zero)
  );

  dma_engine #(.DW(DW), .AW(AW)) u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .go            (go),
    .dir           (dir_q),
    .steal         (steal_q),
    .cnt_last      (cnt_last),
    .cnt_zero      (cnt_zero),
    .addr          (addr_q),
    .bus_grant     (bus_grant),
    .bus_req       (bus_req),
    .busy          (busy),
    .step          (step),
    .mem_addr      (mem_addr),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .dev_out_valid (dev_out_valid),
    .dev_out_ready (dev_out_ready),
    .dev_out_data  (dev_out_data),
    .dev_in_valid  (dev_in_valid),
    .dev_in_ready  (dev_in_ready),
    .dev_in_data   (dev_in_data)
  );

  assign irq = done_q;

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!bus_req && !irq && !mem_rd && !mem_wr));
endmodule

// File: tb/dma_ctrl_tb.sv
module dma_ctrl_tb;
  localparam int DW = 16;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [1:0] cpu_rsel = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, bus_grant;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic dev_out_valid, dev_in_ready;
  logic dev_out_ready = 1'b0;
  logic [DW-1:0] dev_out_data;
  logic dev_in_valid = 1'b0;
  logic [DW-1:0] dev_in_data = '0;
  logic irq;

  always #5 clk = ~clk;

  dma_ctrl #(.DW(DW), .AW(AW), .CW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_rsel(cpu_rsel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
    .dev_out_data(dev_out_data), .dev_in_valid(dev_in_valid),
    .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_all();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // bus owner model
  logic grant_i = 1'b0, force_grant = 1'b0, hold_off = 1'b0, gprev = 1'b0, rprev = 1'b0;
  int gdly = 0, tenures = 0, req_rises = 0, strobes = 0, bad_strobe = 0;
  assign bus_grant = grant_i | force_grant;

  always @(posedge clk) begin
    gprev <= bus_grant;
    rprev <= bus_req;
    if (bus_grant && !gprev) tenures <= tenures + 1;
    if (bus_req && !rprev) req_rises <= req_rises + 1;
    if (mem_rd || mem_wr) strobes <= strobes + 1;
    if ((mem_rd || mem_wr) && (!bus_grant || (mem_rd && mem_wr))) bad_strobe <= bad_strobe + 1;
    if (!rst_n) grant_i <= 1'b0;
    else if (bus_req && !grant_i && !hold_off) begin
      if (gdly == 0) begin grant_i <= 1'b1; gdly <= $urandom_range(0, 3); end
      else gdly <= gdly - 1;
    end else if (!bus_req && grant_i) grant_i <= 1'b0;
  end

  // memory model
  logic [DW-1:0] mem [0:255];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= DW'(i * 40503 + 17);
    end else begin
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  // device sink
  logic [DW-1:0] got [0:31];
  int ngot = 0, stab_err = 0;
  bit out_clr = 0, pv = 0, pr = 0;
  logic [DW-1:0] pd = '0;
  always @(posedge clk) begin
    dev_out_ready <= ($urandom_range(0, 2) != 0);
    pv <= dev_out_valid; pr <= dev_out_ready; pd <= dev_out_data;
    if (pv && !pr && (!dev_out_valid || dev_out_data != pd)) stab_err <= stab_err + 1;
    if (out_clr) ngot <= 0;
    else if (dev_out_valid && dev_out_ready) begin
      if (ngot < 32) got[ngot] <= dev_out_data;
      ngot <= ngot + 1;
    end
  end

  // device source
  logic [DW-1:0] src [0:31];
  int src_n = 0, in_idx = 0;
  bit in_clr = 0;
  always @(posedge clk) begin
    int nx;
    if (in_clr) begin
      in_idx <= 0; dev_in_valid <= 1'b0;
    end else if (!(dev_in_valid && !dev_in_ready)) begin
      nx = in_idx + ((dev_in_valid && dev_in_ready) ? 1 : 0);
      in_idx <= nx;
      if (nx < src_n && $urandom_range(0, 2) != 0) begin
        dev_in_valid <= 1'b1; dev_in_data <= src[nx];
      end else dev_in_valid <= 1'b0;
    end
  end

  task automatic cpu_write(input logic [1:0] rs, input logic [DW-1:0] d);
    @(negedge clk);
    while (bus_grant) @(negedge clk);
    cpu_sel = 1; cpu_wr = 1; cpu_rsel = rs; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic cpu_read(input logic [1:0] rs, output logic [DW-1:0] d);
    @(negedge clk);
    while (bus_grant) @(negedge clk);
    cpu_sel = 1; cpu_wr = 0; cpu_rsel = rs;
    #1 d = cpu_rdata;
    cpu_sel = 0;
  endtask

  task automatic run_xfer(input bit dir, input bit steal, input int n, input int base,
                          input bit hold, input bit poke);
    logic [DW-1:0] exp [0:31];
    logic [DW-1:0] rd;
    int t0, s0, wait_n, errs;
    bit poked;
    for (int i = 0; i < n; i++) begin
      if (dir) src[i] = DW'($urandom);
      else exp[i] = mem[base + i];
    end
    src_n = dir ? n : 0;
    @(negedge clk); in_clr = 1; out_clr = 1;
    @(negedge clk); in_clr = 0; out_clr = 0;
    cpu_write(2'd0, DW'(base));
    cpu_write(2'd1, DW'(n));
    t0 = tenures; s0 = strobes;
    hold_off = hold;
    cpu_write(2'd2, DW'(1 | (dir << 1) | (steal << 2)));
    chk(bus_req == 1'b1, "R4 request after start", bus_req, 1);
    if (hold) begin
      repeat (5) @(negedge clk);
      chk(bus_req && !bus_grant && strobes == s0 && !dev_in_ready && !dev_out_valid,
          "R4 no bus activity before grant", strobes - s0, 0);
      hold_off = 0;
    end
    poked = 0;
    wait_n = 0;
    while (!irq && wait_n < 4000) begin
      @(negedge clk);
      wait_n++;
      if (poke && !poked && !bus_req && !bus_grant && !irq) begin
        poked = 1;
        cpu_sel = 1; cpu_wr = 1; cpu_rsel = 2'd1; cpu_wdata = 16'h0007;
        #1 chk(cpu_rdata == DW'(n - (tenures - t0)), "R7 count between stolen words",
               cpu_rdata, n - (tenures - t0));
        @(negedge clk);
        cpu_sel = 0; cpu_wr = 0;
      end
    end
    chk(irq == 1'b1, "R10 irq at end of run", irq, 1);
    while (bus_req || bus_grant) @(negedge clk);
    repeat (2) @(negedge clk);
    errs = 0;
    if (dir) begin
      for (int i = 0; i < n; i++) if (mem[base + i] != src[i]) errs++;
      chk(errs == 0 && in_idx == n, "R6 device words stored in memory", errs, 0);
    end else begin
      for (int i = 0; i < n; i++) if (got[i] != exp[i]) errs++;
      chk(errs == 0 && ngot == n, "R5 memory words delivered to device", ngot, n);
      chk(stab_err == 0, "R5 offered word held under back-pressure", stab_err, 0);
    end
    if (steal) chk(tenures - t0 == n, "R9 one tenure per word", tenures - t0, n);
    else chk(tenures - t0 == 1, "R8 single tenure for block", tenures - t0, 1);
    cpu_read(2'd0, rd);
    chk(rd == DW'(base + n), "R7 address advanced", rd, base + n);
    cpu_read(2'd1, rd);
    chk(rd == 0, poke ? "R3 count write ignored while running" : "R7 count reached zero", rd, 0);
    cpu_read(2'd2, rd);
    chk(rd == DW'(8 | (dir << 1) | (steal << 2)), "R10 done bit and mode readback",
        rd, 8 | (dir << 1) | (steal << 2));
    cpu_write(2'd2, 16'h0000);
    chk(irq == 1'b0, "R10 control write clears irq", irq, 0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_all();
  end

  initial begin
    logic [DW-1:0] rd;
    int r0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_req && !irq && !mem_rd && !mem_wr && !dev_out_valid && !dev_in_ready,
        "R1 outputs idle after reset", {bus_req, irq, mem_rd, mem_wr}, 0);
    for (int i = 0; i < 3; i++) begin
      cpu_read(2'(i), rd);
      chk(rd == 0, "R1 register zero after reset", rd, 0);
    end

    cpu_write(2'd0, 16'h1234);
    cpu_read(2'd0, rd);
    chk(rd == 16'h1234, "R2 base address readback", rd, 16'h1234);
    cpu_write(2'd1, 16'h0005);
    cpu_read(2'd1, rd);
    chk(rd == 16'h0005, "R2 count readback", rd, 5);
    cpu_write(2'd2, 16'h0006);
    cpu_read(2'd2, rd);
    chk(rd == 16'h0006, "R2 control readback without start", rd, 6);
    cpu_read(2'd3, rd);
    chk(rd == 0, "R2 unused select reads zero", rd, 0);
    chk(bus_req == 0, "R2 no request without start bit", bus_req, 0);

    @(negedge clk); force_grant = 1;
    cpu_sel = 1; cpu_wr = 1; cpu_rsel = 2'd0; cpu_wdata = 16'hBEEF;
    @(negedge clk); cpu_sel = 0; cpu_wr = 0; force_grant = 0;
    @(negedge clk);
    cpu_read(2'd0, rd);
    chk(rd == 16'h1234, "R3 write ignored under grant", rd, 16'h1234);

    cpu_write(2'd1, 16'h0000);
    r0 = req_rises;
    cpu_write(2'd2, 16'h0001);
    chk(irq == 1'b1, "R11 zero count done at once", irq, 1);
    repeat (4) @(negedge clk);
    chk(req_rises == r0 && !bus_req, "R11 no request for zero count", req_rises - r0, 0);
    cpu_write(2'd2, 16'h0000);
    chk(irq == 1'b0, "R10 clear after empty run", irq, 0);

    run_xfer(0, 0, 6, 10, 1, 0);
    run_xfer(1, 0, 5, 40, 0, 0);
    run_xfer(0, 1, 4, 70, 0, 1);
    run_xfer(1, 1, 5, 90, 1, 1);
    run_xfer(0, 0, 1, 120, 0, 0);
    for (int k = 0; k < 8; k++)
      run_xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               $urandom_range(1, 16), $urandom_range(130, 230), 0, 0);

    chk(bad_strobe == 0, "R12 strobes only inside grant and never both", bad_strobe, 0);
    finish_all();
  end
endmodule